// File: doc/BRIEF.md
# Reset-Latched Operating Mode Controller

This block fixes the operating mode of a microcontroller at reset. While the synchronous reset is held, it samples two strap pins on every clock. Each time, it loads three mode control bits and a five-bit priority selector into one control register. When reset is released, the register keeps the values from the last reset cycle. From then on the strap pins have no effect.

The register bits drive the rest of the chip:
- a special-mode flag;
- the expanded-bus enable;
- the bootloader ROM enable, together with a decoder that flags bus addresses inside the ROM window;
- the upper byte of the vector fetch address.

Software reaches the register through a simple read/write port at one address. The mode bits can change only while the special-mode bit is still set. Once software clears the special-mode bit, it stays clear until the next reset. The priority selector is writable in every mode; the logic that consumes it sits outside this block.

Top module: `opmode_ctl`

## Requirements
- R1: While `rst` is 1, the register is reloaded on every clock from the strap pins `strap_b`/`strap_a`. The value loaded on the last reset clock is held after release. The loaded bits {bit7 boot, bit6 spec, bit5 ext} are 0/0/0 for straps 1/0, 0/0/1 for 1/1, 1/1/0 for 0/0, and 0/1/1 for 0/1.
- R2: Reset loads the priority field (bits 4:0) with 5'b00110. A read at address 0x003C returns the whole byte {boot, spec, ext, prio[4:0]}. A read at any other address returns 0x00.
- R3: `mode` equals {spec, ext}: 00 single-chip, 01 expanded, 10 special bootstrap, 11 special test. `special_mode` equals spec and `ext_bus_en` equals ext.
- R4: While spec is 0, a write to 0x003C leaves bits 7:5 unchanged.
- R5: After spec has been cleared, no write sets it again; only reset does.
- R6: While spec is 1, a write to 0x003C loads bits 7, 6 and 5 from the write data.
- R7: `boot_rom_en` equals bit 7. `boot_rom_hit` is 1 exactly when bit 7 is 1 and `bus_addr` lies in 0xBE40..0xBFFF inclusive.
- R8: `vec_hi` is 0xBF while spec is 1 and 0xFF while spec is 0.
- R9: A write to 0x003C loads bits 4:0 in every mode. A write to any other address changes nothing.
- R10: A write takes effect on the clock edge where `bus_wr` is 1. All outputs are combinational from the register and `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps sampled while high |
| strap_b | input | 1 | Strap pin B (0 selects a special mode) |
| strap_a | input | 1 | Strap pin A (1 selects bus expansion) |
| bus_addr | input | 16 | Register/decode address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| mode | output | 2 | Current operating mode code |
| special_mode | output | 1 | Special-mode flag |
| ext_bus_en | output | 1 | Expanded buses active |
| boot_rom_en | output | 1 | Bootloader ROM mapped |
| boot_rom_hit | output | 1 | Address inside mapped bootloader ROM window |
| vec_hi | output | 8 | Upper byte of vector fetch addresses |

## Verification
Every output is decoded combinationally from the single register, so a wrong latched bit shows up on the very next observation after the edge that stored it. A bad strap capture shows up as a wrong read byte, mode code or vector byte in the first cycle after reset. A broken write lock shows up one cycle after the offending write, when the mode code changes or the special flag comes back on. The bench reads the register after every write, so corruption can never stay hidden for more than one step.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

    typedef struct packed {
        logic       boot;
        logic       spec;
        logic       ext;
        logic [4:0] prio;
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_SINGLE  = 2'b00,
        MODE_EXPAND  = 2'b01,
        MODE_BOOT    = 2'b10,
        MODE_TEST    = 2'b11
    } opmode_e;

    localparam logic [4:0] PRIO_RST = 5'b00110;

    function automatic ctrl_t strap_init(input logic sb, input logic sa);
        ctrl_t c;
        c.prio = PRIO_RST;
        case ({sb, sa})
            2'b10:   {c.boot, c.spec, c.ext} = 3'b000;
            2'b11:   {c.boot, c.spec, c.ext} = 3'b001;
            2'b00:   {c.boot, c.spec, c.ext} = 3'b110;
            default: {c.boot, c.spec, c.ext} = 3'b011;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/opmode_reg.sv
module opmode_reg
    import opmode_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h003C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_b,
    input  logic              strap_a,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output ctrl_t             cfg
);

    logic  wr_hit;
    ctrl_t wr_val;

    assign wr_hit = bus_wr && (bus_addr == CTRL_ADDR);

    always_comb begin
        wr_val      = cfg;
        wr_val.prio = bus_wdata[4:0];
        if (cfg.spec) begin
            wr_val.boot = bus_wdata[7];
            wr_val.spec = bus_wdata[6];
            wr_val.ext  = bus_wdata[5];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= strap_init(strap_b, strap_a);
        end else if (wr_hit) begin
            cfg <= wr_val;
        end
    end

    AST_PRIO_RESET: assert property (@(posedge clk) rst |=> cfg.prio == PRIO_RST); // R2
    AST_NORMAL_LOCK: assert property (@(posedge clk) disable iff (rst)
        !cfg.spec |=> ($stable(cfg.boot) && $stable(cfg.ext))); // R4
    AST_SPEC_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        !cfg.spec |=> !cfg.spec); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(cfg)); // R9

endmodule

// File: rtl/opmode_map.sv
module opmode_map
    import opmode_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h003C,
    parameter logic [ADDR_W-1:0] ROM_LO    = 16'hBE40,
    parameter logic [ADDR_W-1:0] ROM_HI    = 16'hBFFF,
    parameter logic [7:0]        VEC_NORM  = 8'hFF,
    parameter logic [7:0]        VEC_SPEC  = 8'hBF
) (
    input  ctrl_t             cfg,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        rd_data,
    output opmode_e           mode,
    output logic              special_mode,
    output logic              ext_bus_en,
    output logic              boot_rom_en,
    output logic              boot_rom_hit,
    output logic [7:0]        vec_hi
);

    logic in_window;

    assign in_window    = (bus_addr >= ROM_LO) && (bus_addr <= ROM_HI);
    assign rd_data      = (bus_addr == CTRL_ADDR) ? cfg : 8'h00;
    assign mode         = opmode_e'({cfg.spec, cfg.ext});
    assign special_mode = cfg.spec;
    assign ext_bus_en   = cfg.ext;
    assign boot_rom_en  = cfg.boot;
    assign boot_rom_hit = cfg.boot && in_window;
    assign vec_hi       = cfg.spec ? VEC_SPEC : VEC_NORM;

endmodule

// File: rtl/opmode_ctl.sv
module opmode_ctl
    import opmode_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h003C,
    parameter logic [ADDR_W-1:0] ROM_LO    = 16'hBE40,
    parameter logic [ADDR_W-1:0] ROM_HI    = 16'hBFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_b,
    input  logic              strap_a,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        rd_data,
    output logic [1:0]        mode,
    output logic              special_mode,
    output logic              ext_bus_en,
    output logic              boot_rom_en,
    output logic              boot_rom_hit,
    output logic [7:0]        vec_hi
);

    ctrl_t   cfg;
    opmode_e mode_e;

    opmode_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .strap_b   (strap_b),
        .strap_a   (strap_a),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cfg       (cfg)
    );

    opmode_map #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
                 .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)) u_map (
        .cfg          (cfg),
        .bus_addr     (bus_addr),
        .rd_data      (rd_data),
        .mode         (mode_e),
        .special_mode (special_mode),
        .ext_bus_en   (ext_bus_en),
        .boot_rom_en  (boot_rom_en),
        .boot_rom_hit (boot_rom_hit),
        .vec_hi       (vec_hi)
    );

    assign mode = mode_e;

    AST_HIT_NEEDS_MAP: assert property (@(posedge clk) disable iff (rst)
        boot_rom_hit |-> boot_rom_en); // R7
    AST_VEC_STAYS_NORMAL: assert property (@(posedge clk) disable iff (rst)
        !special_mode |=> vec_hi == 8'hFF); // R8
    AST_RESET_MODE: assert property (@(posedge clk)
        rst |=> mode == {~$past(strap_b), $past(strap_a)}); // R1

endmodule

// File: tb/sim_opmode_ctl.sv
module sim_opmode_ctl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_b = 1'b1, strap_a = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  rd_data, vec_hi;
    logic [1:0]  mode;
    logic        special_mode, ext_bus_en, boot_rom_en, boot_rom_hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [21:0] exp;
        string       req;
    } item_t;
    item_t q[$];

    logic       m_boot, m_spec, m_ext;
    logic [4:0] m_prio;
    bit         m_ok = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opmode_ctl u0 (
        .clk(clk), .rst(rst), .strap_b(strap_b), .strap_a(strap_a),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .mode(mode), .special_mode(special_mode),
        .ext_bus_en(ext_bus_en), .boot_rom_en(boot_rom_en),
        .boot_rom_hit(boot_rom_hit), .vec_hi(vec_hi)
    );

    function automatic logic [21:0] expect_obs(input logic [15:0] ad);
        logic [7:0] rd;
        logic       hit;
        rd  = (ad == 16'h003C) ? {m_boot, m_spec, m_ext, m_prio} : 8'h00;
        hit = m_boot && (ad >= 16'hBE40) && (ad <= 16'hBFFF);
        return {rd, m_spec, m_ext, m_spec, m_ext, m_boot, hit,
                (m_spec ? 8'hBF : 8'hFF)};
    endfunction

    task automatic step(input logic r, input logic sb, input logic sa,
                        input logic [15:0] ad, input logic w,
                        input logic [7:0] wd, input string req);
        item_t it;
        rst = r; strap_b = sb; strap_a = sa;
        bus_addr = ad; bus_wr = w; bus_wdata = wd;
        if (m_ok) begin
            it.exp = expect_obs(ad);
            it.req = req;
            q.push_back(it);
        end
        @(posedge clk);
        if (r) begin
            m_prio = 5'b00110;
            case ({sb, sa})
                2'b10:   {m_boot, m_spec, m_ext} = 3'b000;
                2'b11:   {m_boot, m_spec, m_ext} = 3'b001;
                2'b00:   {m_boot, m_spec, m_ext} = 3'b110;
                default: {m_boot, m_spec, m_ext} = 3'b011;
            endcase
            m_ok = 1;
        end else if (w && ad == 16'h003C) begin
            m_prio = wd[4:0];
            if (m_spec) begin
                m_boot = wd[7]; m_spec = wd[6]; m_ext = wd[5];
            end
        end
        #1;
    endtask

    task automatic rd(input logic [15:0] ad, input string req);
        step(1'b0, strap_b, strap_a, ad, 1'b0, 8'h00, req);
    endtask

    task automatic wr(input logic [7:0] wd, input string req);
        step(1'b0, strap_b, strap_a, 16'h003C, 1'b1, wd, req);
    endtask

    // Monitor: compares every queued expectation away from the clock edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [21:0] got;
            it  = q.pop_front();
            got = {rd_data, mode, special_mode, ext_bus_en, boot_rom_en,
                   boot_rom_hit, vec_hi};
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s got %h expected %h", it.req, got, it.exp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        // R1: straps change during reset; the last reset cycle wins (bootstrap)
        step(1'b1, 1'b1, 1'b0, 16'h003C, 1'b0, 8'h00, "R1");
        step(1'b1, 1'b1, 1'b1, 16'h003C, 1'b0, 8'h00, "R1");
        step(1'b1, 1'b0, 1'b0, 16'h003C, 1'b0, 8'h00, "R1");
        rd(16'h003C, "R1 R2 bootstrap reset byte");
        // R1: straps after reset have no effect
        step(1'b0, 1'b1, 1'b1, 16'h003C, 1'b0, 8'h00, "R1 straps ignored");
        rd(16'h0040, "R2 other address reads zero");
        rd(16'hBE3F, "R7 below window");
        rd(16'hBE40, "R7 window low edge");
        rd(16'hBFFF, "R7 window high edge");
        rd(16'hC000, "R7 above window");
        // R6: special mode, set ext and prio
        wr(8'hE5, "R6 write in special");
        rd(16'h003C, "R6 R3 special test code");
        rd(16'hBF00, "R7 hit while mapped");
        // R9: write elsewhere ignored
        step(1'b0, 1'b1, 1'b1, 16'h0100, 1'b1, 8'h00, "R9");
        rd(16'h003C, "R9 other address write ignored");
        // R6 R8: clear spec and boot
        wr(8'h25, "R6 clear spec");
        rd(16'h003C, "R8 R3 expanded after clear");
        rd(16'hBE40, "R7 unmapped no hit");
        // R5: try to set spec again
        wr(8'hC9, "R5 set attempt");
        rd(16'h003C, "R5 spec stays clear R9 prio written");
        // R4: try to clear ext in normal mode
        wr(8'h03, "R4 lock attempt");
        rd(16'h003C, "R4 ext kept");
        // Special test reset
        step(1'b1, 1'b0, 1'b1, 16'h003C, 1'b0, 8'h00, "R1");
        rd(16'h003C, "R1 R3 special test reset");
        // Single-chip reset
        step(1'b1, 1'b1, 1'b0, 16'h003C, 1'b0, 8'h00, "R1");
        rd(16'h003C, "R1 single-chip reset");
        wr(8'hFF, "R4 R9 write all ones normal");
        rd(16'h003C, "R4 R9 only prio changes");
        // Expanded reset
        step(1'b1, 1'b1, 1'b1, 16'h003C, 1'b0, 8'h00, "R1");
        rd(16'h003C, "R1 R3 expanded reset");
        // R10: write edge then immediate observation
        wr(8'h11, "R10");
        rd(16'h003C, "R10 update seen next cycle");
        @(negedge clk); #1;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule